// File: doc/BRIEF.md
# Interrupt Response Sequencer

This block sits beside an instruction-execution core. It is sampled once at every instruction boundary and decides whether the core must service an interrupt. Two request types are recognised: a non-maskable request and a maskable request. When one is accepted, the sequencer runs the acknowledge recipe for that request type. It leaves halt if the core was halted and pushes the return address onto the stack through a byte-wide memory request port. For the table mode, it fetches the handler address from a vector table. It then commits the new program counter, the new stack pointer and the updated interrupt-enable state in a single-cycle commit pulse.

The core supplies its current program counter, stack pointer, enable flip-flops, halt state, interrupt mode, the page register and the byte placed on the data bus during acknowledge. The sequencer returns strobes telling the core to clear the flag-tracking latch, bump the refresh counter and leave halt. On the commit pulse the core loads the returned program counter into both its PC and its internal memory pointer, clears the primary enable flip-flop and writes the secondary one. A one-shot suppress strobe lets an instruction, such as a prefix, keep the next boundary free of interrupt sampling.

Top module: `intr_resp_seq`

## Requirements
- R1: While reset is held and just after it, `busy`, `done` and `mem_req` are 0.
- R2: At a sampled boundary the non-maskable request wins over the maskable one. The maskable request is accepted only when `iff1_in` is 1. With neither request accepted, nothing starts and `busy` stays 0.
- R3: A non-maskable acknowledge commits PC 0x0066, and `iff2_out` equals `iff2_in` as sampled at acceptance. `done` rises 8 cycles after the accepting boundary cycle: 5 idle cycles, two pushes and the commit cycle.
- R4: A maskable acknowledge commits `iff2_out` = 0 and pulses `r_inc` in the accepting cycle. A non-maskable acknowledge does not pulse `r_inc`.
- R5: A maskable acknowledge in mode 0, 1 or 3 (`im_sel` = 00, 01, 11) commits PC 0x0038. `done` follows 10 cycles after acceptance: two pushes, 7 idle cycles and the commit cycle.
- R6: In mode 2 (`im_sel` = 10), after the pushes the block reads the low byte at address {`ireg`,`ack_byte`} and then the high byte at that address plus 1. It commits the little-endian word read, and `done` follows 12 cycles after acceptance.
- R7: If `halted_in` is 1 at acceptance, `halt_clr` pulses in the accepting cycle and the pushed return address is `pc_in` + 1.
- R8: The push writes the high byte at SP-1 and then the low byte at SP-2, using 16-bit wrap-around. `sp_out` commits SP-2. Each memory request holds until `mem_ack` and reports `mem_wait` = 3.
- R9: A `skip_set` pulse makes the next boundary ignore both requests. The boundary after that samples normally.
- R10: `done` is a single-cycle pulse, after which `busy` is 0. `q_clr` pulses in every accepting cycle.
- R11: A boundary that arrives while `busy` is 1 is ignored. No `q_clr` is produced and the running sequence completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_end | input | 1 | Instruction boundary strobe |
| skip_set | input | 1 | Suppress interrupt sampling at the next boundary |
| nmi_lvl | input | 1 | Non-maskable request level |
| int_lvl | input | 1 | Maskable request level |
| im_sel | input | 2 | Interrupt mode |
| ireg | input | 8 | Vector table page register |
| ack_byte | input | 8 | Data byte supplied during acknowledge |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| iff1_in | input | 1 | Primary enable flip-flop |
| iff2_in | input | 1 | Secondary enable flip-flop |
| halted_in | input | 1 | Core is halted |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 8 | Write data |
| mem_wait | output | 4 | Cycle charge of the current access |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| busy | output | 1 | Sequence running |
| done | output | 1 | Commit pulse |
| pc_out | output | 16 | New program counter and memory pointer |
| sp_out | output | 16 | New stack pointer |
| iff2_out | output | 1 | New secondary enable value |
| halt_clr | output | 1 | Leave-halt pulse |
| r_inc | output | 1 | Refresh counter increment pulse |
| q_clr | output | 1 | Flag-tracking latch clear pulse |

## Verification
A wrong captured request type shows up as the wrong commit vector and the wrong `iff2_out`. It also appears earlier, as a mismatch in when the first push appears: 5 cycles late for the non-maskable path, immediately for the maskable one. A bad stack pointer or return address is exposed on the first memory write, one cycle after acceptance for maskable requests. A stale suppress flag or a stale mode-2 flag shows within the same boundary, as a missing or extra `q_clr` or a stray read request. A miscounted delay shifts `done` by whole cycles, so the commit latency is compared exactly.

// File: rtl/irs_pkg.sv
package irs_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PRE,
      S_PUSH_HI,
      S_PUSH_LO,
      S_RD_LO,
      S_RD_HI,
      S_POST,
      S_DONE
   } irs_state_e;

   typedef enum logic [1:0] {
      K_NONE,
      K_NMI,
      K_INT
   } irs_kind_e;

endpackage

// File: rtl/irs_arbiter.sv
module irs_arbiter
   import irs_pkg::*;
(
   input  logic      sample,
   input  logic      nmi_lvl,
   input  logic      int_lvl,
   input  logic      iff1,
   output irs_kind_e kind
);

   always_comb begin
      if (!sample)                kind = K_NONE;
      else if (nmi_lvl)           kind = K_NMI;
      else if (int_lvl && iff1)   kind = K_INT;
      else                        kind = K_NONE;
   end

endmodule

// File: rtl/irs_delay.sv
module irs_delay #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= load_val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
   end

   assign expired = (cnt_q == '0);

   AST_DLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));   // R3

endmodule

// File: rtl/irs_mem_port.sv
module irs_mem_port
   import irs_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  irs_state_e    state,
   input  logic [AW-1:0] sp_base,
   input  logic [AW-1:0] pc_push,
   input  logic [AW-1:0] vec_base,
   output logic          req,
   output logic          we,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] wdata
);

   always_comb begin
      req   = 1'b0;
      we    = 1'b0;
      addr  = '0;
      wdata = '0;
      unique case (state)
         S_PUSH_HI: begin
            req = 1'b1; we = 1'b1;
            addr = sp_base - AW'(1);
            wdata = pc_push[AW-1:AW-DW];
         end
         S_PUSH_LO: begin
            req = 1'b1; we = 1'b1;
            addr = sp_base - AW'(2);
            wdata = pc_push[DW-1:0];
         end
         S_RD_LO: begin
            req = 1'b1;
            addr = vec_base;
         end
         S_RD_HI: begin
            req = 1'b1;
            addr = vec_base + AW'(1);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/intr_resp_seq.sv
module intr_resp_seq
   import irs_pkg::*;
#(
   parameter int          AW        = 16,
   parameter int          DW        = 8,
   parameter int          WAIT_W    = 4,
   parameter int unsigned NMI_WAIT  = 5,
   parameter int unsigned INT_WAIT  = 7,
   parameter int unsigned MEM_COST  = 3,
   parameter logic [15:0] NMI_VEC   = 16'h0066,
   parameter logic [15:0] FIX_VEC   = 16'h0038,
   parameter bit          TABLE_EN  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_end,
   input  logic          skip_set,
   input  logic          nmi_lvl,
   input  logic          int_lvl,
   input  logic [1:0]    im_sel,
   input  logic [DW-1:0] ireg,
   input  logic [DW-1:0] ack_byte,
   input  logic [AW-1:0] pc_in,
   input  logic [AW-1:0] sp_in,
   input  logic          iff1_in,
   input  logic          iff2_in,
   input  logic          halted_in,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [WAIT_W-1:0] mem_wait,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] pc_out,
   output logic [AW-1:0] sp_out,
   output logic          iff2_out,
   output logic          halt_clr,
   output logic          r_inc,
   output logic          q_clr
);

   localparam int unsigned MAXW = (NMI_WAIT > INT_WAIT) ? NMI_WAIT : INT_WAIT;
   localparam int          CW   = $clog2(MAXW + 1);

   if (AW != 2 * DW) begin : g_bad_width
      $error("address width must be twice the data width");
   end
   if (NMI_WAIT < 1 || INT_WAIT < 1) begin : g_bad_wait
      $error("delay counts must be at least one");
   end
   if (MEM_COST >= (1 << WAIT_W)) begin : g_bad_cost
      $error("memory cost does not fit the wait field");
   end

   irs_state_e    state_q, state_d;
   irs_kind_e     kind, kind_q;
   logic          mode2_q, iff2_q, skip_q;
   logic [AW-1:0] pc_q, sp_q, vec_q;
   logic [DW-1:0] lo_q;
   logic          idle, sample, accept, table_sel;
   logic          dly_load, dly_done;
   logic [CW-1:0] dly_val;

   assign idle   = (state_q == S_IDLE);
   assign sample = step_end && idle && !skip_q;
   assign accept = (kind != K_NONE);

   if (TABLE_EN) begin : g_table
      assign table_sel = (im_sel == 2'd2);
   end else begin : g_fixed
      assign table_sel = 1'b0;
   end

   irs_arbiter u_arb (
      .sample (sample),
      .nmi_lvl(nmi_lvl),
      .int_lvl(int_lvl),
      .iff1   (iff1_in),
      .kind   (kind)
   );

   irs_mem_port #(.AW(AW), .DW(DW)) u_port (
      .state   (state_q),
      .sp_base (sp_q),
      .pc_push (pc_q),
      .vec_base(vec_q),
      .req     (mem_req),
      .we      (mem_we),
      .addr    (mem_addr),
      .wdata   (mem_wdata)
   );

   irs_delay #(.CW(CW)) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (dly_load),
      .load_val(dly_val),
      .expired (dly_done)
   );

   always_comb begin
      state_d  = state_q;
      dly_load = 1'b0;
      dly_val  = CW'(INT_WAIT - 1);
      unique case (state_q)
         S_IDLE: if (accept) begin
            if (kind == K_NMI) begin
               state_d  = S_PRE;
               dly_load = 1'b1;
               dly_val  = CW'(NMI_WAIT - 1);
            end else begin
               state_d  = S_PUSH_HI;
            end
         end
         S_PRE:     if (dly_done) state_d = S_PUSH_HI;
         S_PUSH_HI: if (mem_ack)  state_d = S_PUSH_LO;
         S_PUSH_LO: if (mem_ack) begin
            if (kind_q == K_NMI)  state_d = S_DONE;
            else if (mode2_q)     state_d = S_RD_LO;
            else begin
               state_d  = S_POST;
               dly_load = 1'b1;
            end
         end
         S_RD_LO:   if (mem_ack) state_d = S_RD_HI;
         S_RD_HI:   if (mem_ack) begin
            state_d  = S_POST;
            dly_load = 1'b1;
         end
         S_POST:    if (dly_done) state_d = S_DONE;
         S_DONE:    state_d = S_IDLE;
         default:   state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         kind_q  <= K_NONE;
         mode2_q <= 1'b0;
         iff2_q  <= 1'b0;
         skip_q  <= 1'b0;
         pc_q    <= '0;
         sp_q    <= '0;
         vec_q   <= '0;
         lo_q    <= '0;
      end else begin
         state_q <= state_d;
         if (skip_set)               skip_q <= 1'b1;
         else if (step_end && idle)  skip_q <= 1'b0;
         unique case (state_q)
            S_IDLE: if (accept) begin
               kind_q  <= kind;
               mode2_q <= table_sel && (kind == K_INT);
               pc_q    <= pc_in + AW'(halted_in);
               sp_q    <= sp_in;
               vec_q   <= {ireg, ack_byte};
               iff2_q  <= (kind == K_NMI) ? iff2_in : 1'b0;
            end
            S_PUSH_LO: if (mem_ack) begin
               sp_q <= sp_q - AW'(2);
               if (kind_q == K_NMI)  pc_q <= NMI_VEC;
               else if (!mode2_q)    pc_q <= FIX_VEC;
            end
            S_RD_LO: if (mem_ack) lo_q <= mem_rdata;
            S_RD_HI: if (mem_ack) pc_q <= {mem_rdata, lo_q};
            default: ;
         endcase
      end
   end

   assign mem_wait = mem_req ? WAIT_W'(MEM_COST) : '0;
   assign busy     = !idle;
   assign done     = (state_q == S_DONE);
   assign pc_out   = pc_q;
   assign sp_out   = sp_q;
   assign iff2_out = iff2_q;
   assign q_clr    = accept;
   assign r_inc    = (kind == K_INT);
   assign halt_clr = accept && halted_in;

   AST_INT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      r_inc |-> (iff1_in && !nmi_lvl));                          // R2
   AST_INT_IFF2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode2_q) |-> !iff2_out);                          // R4
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));                                // R10
   AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !q_clr);                                          // R11

endmodule

// File: tb/intr_resp_seq_tb.sv
`timescale 1ns/100ps
module intr_resp_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_end = 0, skip_set = 0, nmi_lvl = 0, int_lvl = 0;
   logic [1:0]  im_sel = 0;
   logic [7:0]  ireg = 0, ack_byte = 0;
   logic [15:0] pc_in = 0, sp_in = 0;
   logic        iff1_in = 0, iff2_in = 0, halted_in = 0;
   logic        mem_req, mem_we, mem_ack;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic [3:0]  mem_wait;
   logic        busy, done, iff2_out, halt_clr, r_inc, q_clr;
   logic [15:0] pc_out, sp_out;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] model(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   assign mem_ack   = mem_req;
   assign mem_rdata = model(mem_addr);

   intr_resp_seq u_dut (
      .clk(clk), .rst_n(rst_n), .step_end(step_end), .skip_set(skip_set),
      .nmi_lvl(nmi_lvl), .int_lvl(int_lvl), .im_sel(im_sel), .ireg(ireg),
      .ack_byte(ack_byte), .pc_in(pc_in), .sp_in(sp_in), .iff1_in(iff1_in),
      .iff2_in(iff2_in), .halted_in(halted_in), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_wait(mem_wait), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out),
      .iff2_out(iff2_out), .halt_clr(halt_clr), .r_inc(r_inc), .q_clr(q_clr)
   );

   typedef struct { logic we; logic [15:0] addr; logic [7:0] data; string tag; } bus_t;
   typedef struct { logic [15:0] pc; logic [15:0] sp; logic iff2; int lat; int start; string tag; } res_t;

   bus_t bq[$];
   res_t rq[$];
   int checks = 0, fails = 0, cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   // monitor: pops expected bus items and results as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && mem_ack) begin
            if (bq.size() == 0) chk("R8", "unexpected access", 32'(mem_addr), 32'hFFFFFFFF);
            else begin
               bus_t b;
               b = bq.pop_front();
               chk(b.tag, "access kind", 32'(mem_we), 32'(b.we));
               chk(b.tag, "access addr", 32'(mem_addr), 32'(b.addr));
               if (b.we) chk(b.tag, "write data", 32'(mem_wdata), 32'(b.data));
               chk("R8", "wait charge", 32'(mem_wait), 32'd3);
            end
         end
         if (done) begin
            if (rq.size() == 0) chk("R10", "unexpected done", 32'd1, 32'd0);
            else begin
               res_t r;
               r = rq.pop_front();
               chk(r.tag, "new pc", 32'(pc_out), 32'(r.pc));
               chk("R8", "new sp", 32'(sp_out), 32'(r.sp));
               chk(r.tag, "iff2", 32'(iff2_out), 32'(r.iff2));
               chk(r.tag, "latency", 32'(cyc - r.start), 32'(r.lat));
            end
         end
      end
   end

   // driver: called at a falling edge, returns one falling edge later
   task automatic start_case(input bit nmi, input bit intr, input bit i1, input bit i2,
                             input bit hlt, input bit supp, input logic [1:0] im,
                             input logic [7:0] iv, input logic [7:0] ab,
                             input logic [15:0] pc, input logic [15:0] sp,
                             input string tag);
      bit tn, ti;
      logic [15:0] pp, vec, npc;
      int lat;
      tn  = !supp && nmi;
      ti  = !supp && !nmi && intr && i1;
      pp  = pc + 16'(hlt);
      vec = {iv, ab};
      if (tn || ti) begin
         bq.push_back('{1'b1, sp - 16'd1, pp[15:8], tag});
         bq.push_back('{1'b1, sp - 16'd2, pp[7:0], tag});
         if (ti && im == 2'd2) begin
            bq.push_back('{1'b0, vec, 8'h00, tag});
            bq.push_back('{1'b0, vec + 16'd1, 8'h00, tag});
            npc = {model(vec + 16'd1), model(vec)};
            lat = 2 + 2 + 7 + 1;
         end else begin
            npc = tn ? 16'h0066 : 16'h0038;
            lat = tn ? (5 + 2 + 1) : (2 + 7 + 1);
         end
         rq.push_back('{npc, sp - 16'd2, tn ? i2 : 1'b0, lat, cyc, tag});
      end
      nmi_lvl = nmi; int_lvl = intr; iff1_in = i1; iff2_in = i2;
      halted_in = hlt; im_sel = im; ireg = iv; ack_byte = ab;
      pc_in = pc; sp_in = sp; step_end = 1'b1;
      #1;
      chk(tag, "q_clr (R10)", 32'(q_clr), 32'(tn || ti));
      chk(tag, "r_inc (R4)", 32'(r_inc), 32'(ti));
      chk(tag, "halt_clr (R7)", 32'(halt_clr), 32'((tn || ti) && hlt));
      @(negedge clk);
      step_end = 1'b0; nmi_lvl = 1'b0; int_lvl = 1'b0; halted_in = 1'b0;
      chk(tag, "busy after boundary", 32'(busy), 32'(tn || ti));
   endtask

   task automatic finish_case(input string tag);
      int n = 0;
      while (!done && n < 60) begin
         @(negedge clk);
         n++;
      end
      chk(tag, "done seen", 32'(done), 32'd1);
      @(negedge clk);
      chk("R10", "done single pulse", 32'(done), 32'd0);
      chk("R10", "idle after done", 32'(busy), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected finished");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "busy in reset", 32'(busy), 32'd0);
      chk("R1", "done in reset", 32'(done), 32'd0);
      chk("R1", "mem_req in reset", 32'(mem_req), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy after reset", 32'(busy), 32'd0);
      chk("R1", "mem_req after reset", 32'(mem_req), 32'd0);

      // R3 plain non-maskable, enables kept
      start_case(1, 0, 1, 1, 0, 0, 2'd0, 8'h00, 8'h00, 16'h1234, 16'h8000, "R3");
      finish_case("R3");
      // R2 priority: both requests, iff2 low is preserved
      start_case(1, 1, 1, 0, 0, 0, 2'd2, 8'h40, 8'h10, 16'hBEEF, 16'hC000, "R2");
      finish_case("R2");
      // R4 / R5 maskable modes 0, 1, 3
      start_case(0, 1, 1, 1, 0, 0, 2'd0, 8'h00, 8'hFF, 16'h0100, 16'h9000, "R4");
      finish_case("R4");
      start_case(0, 1, 1, 1, 0, 0, 2'd1, 8'h00, 8'h00, 16'h2000, 16'h9100, "R5");
      finish_case("R5");
      start_case(0, 1, 1, 0, 0, 0, 2'd3, 8'h77, 8'h00, 16'h3001, 16'h9200, "R5");
      finish_case("R5");
      // R6 table mode
      start_case(0, 1, 1, 1, 0, 0, 2'd2, 8'h12, 8'h34, 16'h4567, 16'hA000, "R6");
      finish_case("R6");
      start_case(0, 1, 1, 1, 0, 0, 2'd2, 8'hFF, 8'hFF, 16'h0002, 16'hA100, "R6");
      finish_case("R6");
      // R2 gating and idle boundary
      start_case(0, 1, 0, 1, 0, 0, 2'd1, 8'h00, 8'h00, 16'h5000, 16'hB000, "R2");
      start_case(0, 0, 1, 1, 0, 0, 2'd1, 8'h00, 8'h00, 16'h5000, 16'hB000, "R2");
      // R7 halt exit on both paths
      start_case(1, 0, 0, 1, 1, 0, 2'd0, 8'h00, 8'h00, 16'h60FF, 16'hD000, "R7");
      finish_case("R7");
      start_case(0, 1, 1, 1, 1, 0, 2'd2, 8'h21, 8'h08, 16'hFFFF, 16'hD100, "R7");
      finish_case("R7");
      // R8 stack wrap
      start_case(0, 1, 1, 0, 0, 0, 2'd0, 8'h00, 8'h00, 16'h7777, 16'h0001, "R8");
      finish_case("R8");
      // R9 suppress one boundary, then sample again
      skip_set = 1'b1;
      @(negedge clk);
      skip_set = 1'b0;
      @(negedge clk);
      start_case(1, 0, 1, 1, 0, 1, 2'd0, 8'h00, 8'h00, 16'h1111, 16'hE000, "R9");
      start_case(1, 0, 1, 1, 0, 0, 2'd0, 8'h00, 8'h00, 16'h2222, 16'hE000, "R9");
      finish_case("R9");
      // R11 boundary during a running sequence
      start_case(1, 0, 1, 1, 0, 0, 2'd0, 8'h00, 8'h00, 16'h3333, 16'hF000, "R11");
      step_end = 1'b1; int_lvl = 1'b1; nmi_lvl = 1'b1; iff1_in = 1'b1;
      #1;
      chk("R11", "q_clr while busy", 32'(q_clr), 32'd0);
      chk("R11", "r_inc while busy", 32'(r_inc), 32'd0);
      @(negedge clk);
      step_end = 1'b0; int_lvl = 1'b0; nmi_lvl = 1'b0;
      finish_case("R11");
      repeat (3) @(negedge clk);
      chk("R11", "pending accesses", 32'(bq.size()), 32'd0);
      chk("R10", "pending results", 32'(rq.size()), 32'd0);
      report();
      $finish;
   end

endmodule